// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block sits beside the fetch and load/store stages of a 32-bit soft processor and holds a small bank of debug comparators. Instruction breakpoint slots watch the program counter of the instruction about to execute. Data watchpoint slots watch the byte address of each load or store. Each watchpoint slot is filtered by its own access-kind code. When a comparator hits, the unit raises one of two exception requests: one for an instruction breakpoint and one for a data watchpoint. The core uses that request to cancel the matching instruction or memory access before it commits.

Debug software programs the slots through a simple indexed register write port and can read any slot back through a registered read port. A sticky per-slot hit register records which comparators have fired. Software clears its bits by writing ones to them. Both request outputs are registered, so they appear one clock after the PC or access is presented. The core is expected to hold the access in its stage until that clock has passed.

Top module: `dbgm_unit`

## Requirements
- R1: After synchronous reset, `brk_req` and `wp_req` are 0, every slot is disabled, and every register index reads back 0.
- R2: A breakpoint slot at index i (0..3) is written with {address[31:2], bit1 ignored, enable in bit 0}. While the slot is enabled, `pc_valid` with `pc[31:2]` equal to the stored address raises `brk_req` for exactly the following cycle. `pc[1:0]` plays no part in the comparison.
- R3: A breakpoint slot whose enable bit is 0 never raises `brk_req`, whatever its address.
- R4: Each watchpoint slot j (0..3) takes a 32-bit address at index 4+j and a 2-bit kind in bits 1:0 at index 8+j. Kind 1 matches loads only (`rd_stb`), kind 2 matches stores only (`wr_stb`), and kind 3 matches either. A match raises `wp_req` in the following cycle.
- R5: A watchpoint slot of kind 0 never produces a match, whatever its address or strobes.
- R6: A watchpoint compares all 32 address bits, so an access one byte away from the programmed address does not match.
- R7: A request appears only in the cycle after a valid PC (`brk_req`) or an asserted strobe (`wp_req`). With no `pc_valid` or strobe, no request appears, even if the address equals a programmed slot.
- R8: When a breakpoint and a watchpoint hit in the same cycle, only `brk_req` is raised.
- R9: Index 12 is the sticky hit register. Bits 3:0 are breakpoint slots and bits 7:4 are watchpoint slots. A hit sets its slot's bit. Writing ones clears those bits. A hit in the same cycle as a clear keeps its bit set.
- R10: Reads are registered: `cfg_rdata` shows the register selected by `cfg_raddr` one cycle later. A breakpoint register reads with bit 1 as 0, and a kind register reads only bits 1:0.
- R11: Writing zero to a slot that is already empty leaves it reading 0, and it produces no hit.
- R12: Writes to indices 13 to 15 change no register, and those indices read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Register index to write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 4 | Register index to read |
| cfg_rdata | output | 32 | Registered read data |
| pc_valid | input | 1 | PC of instruction about to execute is valid |
| pc | input | 32 | Program counter |
| rd_stb | input | 1 | Load access presented |
| wr_stb | input | 1 | Store access presented |
| daddr | input | 32 | Byte address of the data access |
| brk_req | output | 1 | Breakpoint exception request |
| wp_req | output | 1 | Watchpoint exception request |

## Verification
Four properties are checked on every cycle. The two requests are never raised together. A request never appears without a valid PC or data strobe in the cycle before. Both requests are quiet right after reset. Sticky hit bits drop only after a write to the status index. The address comparison, the kind filtering, the ignored low PC bits, the one-byte neighbour cases and the readback values depend on what was programmed, so only the directed scenarios can show them.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    WK_OFF  = 2'd0,
    WK_LOAD = 2'd1,
    WK_STORE = 2'd2,
    WK_ANY  = 2'd3
  } wp_kind_e;

  function automatic logic kind_hit(input wp_kind_e k, input logic ld, input logic st);
    case (k)
      WK_LOAD:  kind_hit = ld;
      WK_STORE: kind_hit = st;
      WK_ANY:   kind_hit = ld | st;
      default:  kind_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbgm_bp_slot.sv
module dbgm_bp_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  input  logic          pc_valid,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] reg_val,
  output logic          hit
);
  logic [AW-1:2] addr_q;
  logic          en_q;
  logic          unused_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      addr_q <= wdata[AW-1:2];
      en_q   <= wdata[0];
    end
  end

  // instructions are word aligned: the low PC bits take no part
  assign hit         = en_q && pc_valid && (pc[AW-1:2] == addr_q);
  assign reg_val     = {addr_q, 1'b0, en_q};
  assign unused_bits = ^{pc[1:0], wdata[1]};
endmodule

// File: rtl/dbgm_wp_slot.sv
module dbgm_wp_slot
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_we,
  input  logic          kind_we,
  input  logic [AW-1:0] wdata,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [AW-1:0] daddr,
  output logic [AW-1:0] addr_val,
  output logic [1:0]    kind_val,
  output logic          hit
);
  logic [AW-1:0] addr_q;
  wp_kind_e      kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      kind_q <= WK_OFF;
    end else begin
      if (addr_we) addr_q <= wdata;
      if (kind_we) kind_q <= wp_kind_e'(wdata[1:0]);
    end
  end

  assign hit      = kind_hit(kind_q, rd_stb, wr_stb) && (daddr == addr_q);
  assign addr_val = addr_q;
  assign kind_val = kind_q;
endmodule

// File: rtl/dbgm_unit.sv
module dbgm_unit #(
  parameter int AW     = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int RAW    = $clog2(NUM_BP + 2*NUM_WP + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_waddr,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [RAW-1:0] cfg_raddr,
  output logic [AW-1:0]  cfg_rdata,
  input  logic           pc_valid,
  input  logic [AW-1:0]  pc,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [AW-1:0]  daddr,
  output logic           brk_req,
  output logic           wp_req
);
  localparam int WA_BASE  = NUM_BP;
  localparam int WK_BASE  = NUM_BP + NUM_WP;
  localparam int STAT_IDX = NUM_BP + 2*NUM_WP;
  localparam int NS       = NUM_BP + NUM_WP;

  logic [NUM_BP-1:0]  bp_hit;
  logic [NUM_WP-1:0]  wp_hit;
  logic [AW-1:0]      bp_val [NUM_BP];
  logic [AW-1:0]      wa_val [NUM_WP];
  logic [1:0]         wk_val [NUM_WP];
  logic [NS-1:0]      sticky_q;
  logic [AW-1:0]      rd_next;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dbgm_bp_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_waddr == RAW'(i))),
      .wdata    (cfg_wdata),
      .pc_valid (pc_valid),
      .pc       (pc),
      .reg_val  (bp_val[i]),
      .hit      (bp_hit[i])
    );
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    dbgm_wp_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .addr_we  (cfg_we && (cfg_waddr == RAW'(WA_BASE + j))),
      .kind_we  (cfg_we && (cfg_waddr == RAW'(WK_BASE + j))),
      .wdata    (cfg_wdata),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .daddr    (daddr),
      .addr_val (wa_val[j]),
      .kind_val (wk_val[j]),
      .hit      (wp_hit[j])
    );
  end

  // requests: breakpoint wins over watchpoint in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      wp_req  <= 1'b0;
    end else begin
      brk_req <= |bp_hit;
      wp_req  <= (|wp_hit) && !(|bp_hit);
    end
  end

  // sticky hit record, write-one-to-clear, new hits win over clears
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
    end else begin
      if (cfg_we && (cfg_waddr == RAW'(STAT_IDX)))
        sticky_q <= (sticky_q & ~cfg_wdata[NS-1:0]) | {wp_hit, bp_hit};
      else
        sticky_q <= sticky_q | {wp_hit, bp_hit};
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_BP; i++)
      if (cfg_raddr == RAW'(i)) rd_next = bp_val[i];
    for (int j = 0; j < NUM_WP; j++) begin
      if (cfg_raddr == RAW'(WA_BASE + j)) rd_next = wa_val[j];
      if (cfg_raddr == RAW'(WK_BASE + j)) rd_next = AW'(wk_val[j]);
    end
    if (cfg_raddr == RAW'(STAT_IDX)) rd_next = AW'(sticky_q);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/dbgm_unit_chk.sv
module dbgm_unit_chk #(
  parameter int RAW      = 4,
  parameter int NS       = 8,
  parameter int STAT_IDX = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           pc_valid,
  input logic           rd_stb,
  input logic           wr_stb,
  input logic           cfg_we,
  input logic [RAW-1:0] cfg_waddr,
  input logic           brk_req,
  input logic           wp_req,
  input logic [NS-1:0]  sticky_q
);
  // R8: breakpoint takes precedence, never both
  a_r8_one_cause: assert property (@(posedge clk) disable iff (rst)
    !(brk_req && wp_req));

  // R7: breakpoint request needs a valid PC one cycle earlier
  a_r7_brk_source: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(pc_valid));

  // R7: watchpoint request needs a strobe one cycle earlier
  a_r7_wp_source: assert property (@(posedge clk) disable iff (rst)
    wp_req |-> $past(rd_stb || wr_stb));

  // R1: requests quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!brk_req && !wp_req));

  // R9: sticky bits fall only after a status write
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !($past(cfg_we) && ($past(cfg_waddr) == RAW'(STAT_IDX)))
      |-> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

bind dbgm_unit dbgm_unit_chk #(
  .RAW      (RAW),
  .NS       (NUM_BP + NUM_WP),
  .STAT_IDX (NUM_BP + 2*NUM_WP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc_valid  (pc_valid),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .cfg_we    (cfg_we),
  .cfg_waddr (cfg_waddr),
  .brk_req   (brk_req),
  .wp_req    (wp_req),
  .sticky_q  (sticky_q)
);

// File: tb/tb_dbgm_unit.sv
module tb_dbgm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] daddr = '0;
  logic        brk_req, wp_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgm_unit dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .pc_valid(pc_valid), .pc(pc), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .daddr(daddr), .brk_req(brk_req), .wp_req(wp_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle from a negedge to the next; outputs sampled at the end
  task automatic cyc(input logic pv, input logic [31:0] p, input logic rs, input logic ws,
                     input logic [31:0] da, input logic we, input logic [3:0] wa,
                     input logic [31:0] wd, input logic [3:0] ra,
                     output logic b, output logic w, output logic [31:0] rdv);
    pc_valid = pv; pc = p; rd_stb = rs; wr_stb = ws; daddr = da;
    cfg_we = we; cfg_waddr = wa; cfg_wdata = wd; cfg_raddr = ra;
    @(posedge clk);
    @(negedge clk);
    b = brk_req; w = wp_req; rdv = cfg_rdata;
    pc_valid = 0; rd_stb = 0; wr_stb = 0; cfg_we = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic b, w; logic [31:0] r;
    cyc(0, 0, 0, 0, 0, 1, a, d, 0, b, w, r);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    logic b, w;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, a, b, w, d);
  endtask

  task automatic pc_probe(input logic pv, input logic [31:0] p, output logic b, output logic w);
    logic [31:0] r;
    cyc(pv, p, 0, 0, 0, 0, 0, 0, 0, b, w, r);
  endtask

  task automatic d_probe(input logic rs, input logic ws, input logic [31:0] a,
                         output logic b, output logic w);
    logic [31:0] r;
    cyc(0, 0, rs, ws, a, 0, 0, 0, 0, b, w, r);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 brk_req", {31'b0, brk_req}, 0);
    chk("R1 wp_req", {31'b0, wp_req}, 0);
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), r);
      chk("R1 readback", r, 0);
    end
  endtask

  task automatic t_breakpoint;
    logic b, w; logic [31:0] r;
    wr(2, 32'h0000_1001);
    pc_probe(1, 32'h0000_1000, b, w);
    chk("R2 hit", {30'b0, b, w}, 32'h2);
    pc_probe(1, 32'h0000_1002, b, w);
    chk("R2 low pc bits ignored", {30'b0, b, w}, 32'h2);
    pc_probe(1, 32'h0000_1004, b, w);
    chk("R2 next word no hit", {30'b0, b, w}, 0);
    pc_probe(0, 32'h0000_1000, b, w);
    chk("R7 no pc_valid", {30'b0, b, w}, 0);
    rd(2, r);
    chk("R10 bp readback", r, 32'h0000_1001);
    wr(2, 32'h0000_1003);
    rd(2, r);
    chk("R10 bit1 reads zero", r, 32'h0000_1001);
  endtask

  task automatic t_bp_disabled;
    logic b, w;
    wr(1, 32'h0000_2000);
    pc_probe(1, 32'h0000_2000, b, w);
    chk("R3 disabled slot", {30'b0, b, w}, 0);
  endtask

  task automatic t_watch_kinds;
    logic b, w; logic [31:0] r;
    wr(4, 32'h0000_3001);
    wr(8, 32'h1);
    d_probe(1, 0, 32'h0000_3001, b, w);
    chk("R4 kind1 load", {30'b0, b, w}, 1);
    d_probe(0, 1, 32'h0000_3001, b, w);
    chk("R4 kind1 store", {30'b0, b, w}, 0);
    wr(8, 32'h2);
    d_probe(1, 0, 32'h0000_3001, b, w);
    chk("R4 kind2 load", {30'b0, b, w}, 0);
    d_probe(0, 1, 32'h0000_3001, b, w);
    chk("R4 kind2 store", {30'b0, b, w}, 1);
    wr(8, 32'hFFFF_FFF3);
    rd(8, r);
    chk("R10 kind readback", r, 3);
    d_probe(1, 0, 32'h0000_3001, b, w);
    chk("R4 kind3 load", {30'b0, b, w}, 1);
    d_probe(0, 1, 32'h0000_3001, b, w);
    chk("R4 kind3 store", {30'b0, b, w}, 1);
    d_probe(1, 1, 32'h0000_3000, b, w);
    chk("R6 byte below", {30'b0, b, w}, 0);
    d_probe(1, 1, 32'h0000_3002, b, w);
    chk("R6 byte above", {30'b0, b, w}, 0);
    d_probe(0, 0, 32'h0000_3001, b, w);
    chk("R7 no strobe", {30'b0, b, w}, 0);
    rd(4, r);
    chk("R10 wp addr readback", r, 32'h0000_3001);
    wr(9, 0);
    wr(5, 32'h0000_4000);
    d_probe(1, 1, 32'h0000_4000, b, w);
    chk("R5 kind0 never", {30'b0, b, w}, 0);
  endtask

  task automatic t_priority;
    logic b, w; logic [31:0] r;
    cyc(1, 32'h0000_1000, 1, 0, 32'h0000_3001, 0, 0, 0, 0, b, w, r);
    chk("R8 breakpoint wins", {30'b0, b, w}, 32'h2);
  endtask

  task automatic t_status;
    logic b, w; logic [31:0] r;
    wr(12, 32'hFF);
    rd(12, r);
    chk("R9 cleared", r, 0);
    pc_probe(1, 32'h0000_1000, b, w);
    d_probe(1, 0, 32'h0000_3001, b, w);
    rd(12, r);
    chk("R9 sticky bits", r, 32'h14);
    wr(12, 32'h04);
    rd(12, r);
    chk("R9 w1c", r, 32'h10);
    cyc(1, 32'h0000_1000, 0, 0, 0, 1, 12, 32'h14, 0, b, w, r);
    rd(12, r);
    chk("R9 hit beats clear", r, 32'h04);
  endtask

  task automatic t_empty_clear;
    logic b, w; logic [31:0] r;
    wr(3, 0);
    rd(3, r);
    chk("R11 bp empty stays", r, 0);
    pc_probe(1, 0, b, w);
    chk("R11 bp empty no hit", {30'b0, b, w}, 0);
    wr(11, 0);
    rd(11, r);
    chk("R11 wp empty stays", r, 0);
    d_probe(1, 1, 0, b, w);
    chk("R11 wp empty no hit", {30'b0, b, w}, 0);
  endtask

  task automatic t_out_of_range;
    logic [31:0] r;
    wr(13, 32'hDEAD_BEEF);
    wr(15, 32'h1234_5679);
    rd(13, r);
    chk("R12 index13 reads 0", r, 0);
    rd(15, r);
    chk("R12 index15 reads 0", r, 0);
    rd(2, r);
    chk("R12 bp slot unchanged", r, 32'h0000_1001);
    rd(4, r);
    chk("R12 wp slot unchanged", r, 32'h0000_3001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_breakpoint();
    t_bp_disabled();
    t_watch_kinds();
    t_priority();
    t_status();
    t_empty_clear();
    t_out_of_range();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule